// File: doc/BRIEF.md
# Multi-Chain Scan Wrapper

This block is a small sequential core whose state bits are all mux-D scan flip-flops. The flip-flops are split into several serial shift chains of unequal length. One test-control pin switches every chain at once between functional capture and serial shifting. No dedicated scan pins exist. Each chain's serial input is taken from a primary input pin, and its serial output is multiplexed onto a primary output pin. Test control steers that multiplexing.

Chain `c` holds `CHAIN_LEN + c` bits. Its serial input is `pi_i[c]` and its serial output appears on `po_o[c]`. Between the registers sits a fixed example function. It lets a tester load a state, apply one functional capture cycle and shift the result back out. The shift depth of a test is set by the longest chain. Shorter chains take extra don't-care bits during that time.

Top module: `scan_wrap_top`

## Requirements
- R1: While `rst_ni` is low, every state bit is 0. After release in functional mode with `pi_i` all zero, every `po_o` bit reads 0.
- R2: With `test_ctrl_i` = 0, each rising clock shifts chain `c` by one place. Bit 0 takes `pi_i[c]`, and bit k takes the old bit k-1.
- R3: With `test_ctrl_i` = 1, each rising clock loads bit k of chain `c` (length L) with `s[(k+L-1) mod L] ^ (pi_i[(c+k) mod PI_W] & s[k])`. Here `s` is that chain's present state.
- R4: With `test_ctrl_i` = 1, `po_o[c]` equals the XOR of all bits of chain `c` XOR `pi_i[PI_W-1]`. This output is combinational.
- R5: With `test_ctrl_i` = 0, `po_o[c]` equals the last bit (bit L-1) of chain `c`. In this mode, `pi_i` bits at index `NUM_CHAINS` and above do not change any state bit.
- R6: Chain `c` has length `CHAIN_LEN + c`. A 1 shifted in on `pi_i[c]` first shows on `po_o[c]` after exactly `CHAIN_LEN + c` shift clocks.
- R7: The chains are independent in shift mode. The data on one chain's serial input never reaches another chain's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Single clock for every flip-flop |
| rst_ni | input | 1 | Active-low asynchronous reset |
| test_ctrl_i | input | 1 | 1 = functional capture, 0 = serial shift |
| pi_i | input | PI_W | Primary inputs; bit c is also the serial input of chain c |
| po_o | output | NUM_CHAINS | Primary outputs; bit c carries the serial output of chain c in shift mode |

## Verification
The assertions assume that the clock reaches the flip-flops directly. They assume that reset is released away from a rising edge. They also assume that `test_ctrl_i` changes only between edges, so a whole cycle is either shift or capture. The bench drives every input on the falling edge and releases reset there too. It mixes random shift and capture cycles with directed shift-through and reset runs. This keeps each cycle's mode unambiguous for the checks that span two edges.

// File: rtl/scan_pkg.sv
package scan_pkg;
  function automatic int chain_len(input int base, input int c);
    return base + c;
  endfunction

  function automatic int chain_off(input int base, input int c);
    return c * base + (c * (c - 1)) / 2;
  endfunction

  function automatic int total_bits(input int base, input int n);
    return n * base + (n * (n - 1)) / 2;
  endfunction
endpackage

// File: rtl/scan_dff.sv
module scan_dff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tc_i,
  input  logic d_i,
  input  logic si_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= tc_i ? d_i : si_i;
  end
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int LEN = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tc_i,
  input  logic [LEN-1:0] d_i,
  input  logic           si_i,
  output logic [LEN-1:0] q_o,
  output logic           so_o
);
  for (genvar k = 0; k < LEN; k++) begin : g_bit
    logic si_k;
    if (k == 0) begin : g_head
      assign si_k = si_i;
    end else begin : g_link
      assign si_k = q_o[k-1];
    end
    scan_dff u_ff (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tc_i  (tc_i),
      .d_i   (d_i[k]),
      .si_i  (si_k),
      .q_o   (q_o[k])
    );
  end

  assign so_o = q_o[LEN-1];

  // R2: serial entry at the head
  p_shift_in_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tc_i |=> q_o[0] == $past(si_i));

  if (LEN > 1) begin : g_shift_chk
    // R2: each bit moves one place per shift clock
    p_shift_move_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tc_i |=> q_o[LEN-1:1] == $past(q_o[LEN-2:0]));
  end

  // R3: capture loads the functional next state
  p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_i |=> q_o == $past(d_i));
endmodule

// File: rtl/scan_logic.sv
module scan_logic
  import scan_pkg::*;
#(
  parameter int NUM_CHAINS = 3,
  parameter int CHAIN_LEN  = 4,
  parameter int PI_W       = 4,
  parameter int TOTAL      = total_bits(CHAIN_LEN, NUM_CHAINS)
) (
  input  logic [TOTAL-1:0]      state_i,
  input  logic [PI_W-1:0]       pi_i,
  output logic [TOTAL-1:0]      next_o,
  output logic [NUM_CHAINS-1:0] po_o
);
  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    localparam int L   = chain_len(CHAIN_LEN, c);
    localparam int OFF = chain_off(CHAIN_LEN, c);
    for (genvar k = 0; k < L; k++) begin : g_bit
      localparam int PREV = (k + L - 1) % L;
      localparam int SEL  = (c + k) % PI_W;
      assign next_o[OFF+k] = state_i[OFF+PREV] ^ (pi_i[SEL] & state_i[OFF+k]);
    end
    assign po_o[c] = (^state_i[OFF+L-1:OFF]) ^ pi_i[PI_W-1];
  end
endmodule

// File: rtl/scan_wrap_top.sv
module scan_wrap_top
  import scan_pkg::*;
#(
  parameter int NUM_CHAINS = 3,
  parameter int CHAIN_LEN  = 4,
  parameter int PI_W       = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  test_ctrl_i,
  input  logic [PI_W-1:0]       pi_i,
  output logic [NUM_CHAINS-1:0] po_o
);
  localparam int TOTAL = total_bits(CHAIN_LEN, NUM_CHAINS);

  logic [TOTAL-1:0]      state;
  logic [TOTAL-1:0]      next_func;
  logic [NUM_CHAINS-1:0] po_func;
  logic [NUM_CHAINS-1:0] so_vec;

  scan_logic #(
    .NUM_CHAINS(NUM_CHAINS),
    .CHAIN_LEN (CHAIN_LEN),
    .PI_W      (PI_W),
    .TOTAL     (TOTAL)
  ) u_logic (
    .state_i(state),
    .pi_i   (pi_i),
    .next_o (next_func),
    .po_o   (po_func)
  );

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    localparam int L   = chain_len(CHAIN_LEN, c);
    localparam int OFF = chain_off(CHAIN_LEN, c);
    scan_chain #(.LEN(L)) u_chain (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tc_i  (test_ctrl_i),
      .d_i   (next_func[OFF+L-1:OFF]),
      .si_i  (pi_i[c]),
      .q_o   (state[OFF+L-1:OFF]),
      .so_o  (so_vec[c])
    );

    if (L > 1) begin : g_out_chk
      // R5: in shift mode the pin shows the bit that sat one place back
      p_po_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!test_ctrl_i ##1 !test_ctrl_i) |-> po_o[c] == $past(state[OFF+L-2]));
    end
  end

  // Output pins shared between function and scan-out
  assign po_o = test_ctrl_i ? po_func : so_vec;

  // R1: reset leaves every state bit clear
  p_reset_clear_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> state == '0);
endmodule

// File: tb/scan_wrap_top_tb_top.sv
module scan_wrap_top_tb_top;
  localparam int NC   = 3;
  localparam int CL   = 4;
  localparam int PIW  = 4;
  localparam int MAXL = CL + NC - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tc = 1'b1;
  logic [PIW-1:0] pi = '0;
  logic [NC-1:0]  po;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [MAXL-1:0] m [NC];

  always #4 clk = ~clk;

  scan_wrap_top #(.NUM_CHAINS(NC), .CHAIN_LEN(CL), .PI_W(PIW)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .test_ctrl_i(tc),
    .pi_i       (pi),
    .po_o       (po)
  );

  function automatic int len_of(int c);
    return CL + c;
  endfunction

  function automatic logic [NC-1:0] exp_po(logic t, logic [PIW-1:0] p);
    logic [NC-1:0] r;
    for (int c = 0; c < NC; c++) begin
      logic par = 1'b0;
      for (int k = 0; k < len_of(c); k++) par ^= m[c][k];
      r[c] = t ? (par ^ p[PIW-1]) : m[c][len_of(c)-1];
    end
    return r;
  endfunction

  task automatic advance_model(logic t, logic [PIW-1:0] p);
    logic [MAXL-1:0] n [NC];
    for (int c = 0; c < NC; c++) begin
      int l = len_of(c);
      n[c] = '0;
      for (int k = 0; k < l; k++) begin
        if (t) n[c][k] = m[c][(k + l - 1) % l] ^ (p[(c + k) % PIW] & m[c][k]);
        else   n[c][k] = (k == 0) ? p[c] : m[c][k-1];
      end
    end
    for (int c = 0; c < NC; c++) m[c] = n[c];
  endtask

  task automatic check(string req, logic [NC-1:0] act, logic [NC-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: po_o act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic step(logic t, logic [PIW-1:0] p);
    @(negedge clk);
    tc = t;
    pi = p;
    #1;
    check(t ? "R3 R4" : "R2 R5 R7", po, exp_po(t, p));
    advance_model(t, p);
  endtask

  task automatic clear_model();
    for (int c = 0; c < NC; c++) m[c] = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int first_hit [NC];
    void'($urandom(32'h5ca1));
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: after reset, functional outputs are zero with zero inputs
    @(negedge clk);
    tc = 1'b1; pi = '0; #1;
    check("R1", po, '0);
    // R1: shifting out a fresh state yields zeros
    for (int i = 0; i < MAXL; i++) begin
      @(negedge clk); tc = 1'b0; pi = '0; #1;
      check("R1", po, '0);
    end
    clear_model();

    // R6: single 1 per chain appears after chain length shifts
    for (int c = 0; c < NC; c++) first_hit[c] = -1;
    for (int n = 0; n <= MAXL + 1; n++) begin
      step(1'b0, (n == 0) ? PIW'((1 << NC) - 1) : '0);
      for (int c = 0; c < NC; c++)
        if (po[c] && first_hit[c] < 0) first_hit[c] = n;
    end
    for (int c = 0; c < NC; c++) begin
      checks++;
      if (first_hit[c] != len_of(c)) begin
        errors++;
        $display("FAIL R6: chain %0d act=%0d exp=%0d", c, first_hit[c], len_of(c));
      end
    end

    // R7: only chain 1 gets data; others must stay zero
    for (int n = 0; n < 2 * MAXL; n++) step(1'b0, PIW'(2));
    // R5: upper pi bit toggled in shift mode must not alter state
    for (int n = 0; n < 2 * MAXL; n++) step(1'b0, PIW'({n[0], 3'b000}));

    // Load, capture, unload patterns
    for (int t = 0; t < 40; t++) begin
      for (int n = 0; n < MAXL; n++) step(1'b0, PIW'($urandom));
      step(1'b1, PIW'($urandom));
      for (int n = 0; n < MAXL; n++) step(1'b0, PIW'($urandom));
    end

    // Random mixed modes
    for (int n = 0; n < 1500; n++) step(1'($urandom), PIW'($urandom));

    // R1: mid-run reset clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    clear_model();
    tc = 1'b1; pi = '0; #1;
    check("R1", po, '0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < MAXL; i++) begin
      @(negedge clk); tc = 1'b0; pi = '0; #1;
      check("R1", po, '0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule